// File: doc/BRIEF.md
# Dataway Command Decoder with Service Request

This block sits between a modular crate's dataway and an eight-channel time digitizer. It decodes the function code and subaddress that the crate controller presents and routes the addressed channel's result onto the read lines. It answers each command with the command-accepted (X) and conditional (Q) responses. It also keeps the service-request flag (LAM) that tells the controller a measurement window has closed. Unit clears and LAM resets take effect on the rising edge of the second strobe. Read data and Q appear while either strobe is high.

The digitizer core supplies a data port that returns a 24-bit two's-complement word and a valid flag for the channel named on `ch_sel`. The LAM is raised by the leading edge of an end-of-window event, which comes either from an external input or from an internal timeout, but only while the LAM-enable option is set. The flag stays set until a command that clears it arrives. The inhibit line passes straight through to the digitizer inputs.

Top module: `dataway_cmd_unit`

## Requirements
- R1: After reset, `lam_req` and `unit_clr` are 0.
- R2: `resp_x` is 1 for these command pairs and 0 for all others: function 0 or 2 with subaddress 0..7, and function 8, 9 or 10 with subaddress 0.
- R3: With function 0 or 2 and subaddress 0..7, while `strobe1` or `strobe2` is high, `ch_sel` equals subaddress[2:0], `rd_data` equals `ch_data`, and `resp_q` equals `ch_valid`. When neither strobe is high, `rd_data` and `resp_q` are 0.
- R4: Function 8 with subaddress 0 answers `resp_q` equal to `lam_req` during a strobe, and changes nothing.
- R5: Function 10 with subaddress 0 answers `resp_q` equal to `lam_req` during `strobe1`. The `strobe2` rising edge then clears the LAM, with no unit clear.
- R6: Function 9 with subaddress 0 clears the LAM at the `strobe2` rising edge. In the following cycle, `unit_clr` pulses high for one cycle.
- R7: Function 2 with subaddress 7 produces the same `unit_clr` pulse at `strobe2`, and leaves `lam_req` unchanged.
- R8: `init_z` or `clear_c` high at a `strobe2` rising edge clears the LAM and pulses `unit_clr`, whatever the function and subaddress.
- R9: A rising edge of (`eow_ext` OR `eow_int`) sets `lam_req` when `lam_en` is 1, and has no effect when `lam_en` is 0. A set LAM stays set until R5, R6 or R8 clears it. An event input that is held high does not set the LAM again.
- R10: An undefined command pair gives `resp_q`=0 and `rd_data`=0, leaves `lam_req` unchanged, and produces no `unit_clr`.
- R11: `inputs_inhibit` follows `inhibit_i`.
- R12: A `strobe2` held high for several cycles acts only once: exactly one `unit_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_fn | input | 5 | Function code |
| cmd_sa | input | 4 | Subaddress |
| strobe1 | input | 1 | First strobe |
| strobe2 | input | 1 | Second strobe |
| init_z | input | 1 | Initialize line |
| clear_c | input | 1 | Clear line |
| inhibit_i | input | 1 | Inhibit line |
| lam_en | input | 1 | LAM-enable option |
| eow_ext | input | 1 | External end-of-window event |
| eow_int | input | 1 | Internal timeout end-of-window event |
| ch_sel | output | 3 | Channel addressed on the data port |
| ch_data | input | 24 | Channel word from the digitizer |
| ch_valid | input | 1 | Channel holds a hit |
| rd_data | output | 24 | Read lines |
| resp_q | output | 1 | Conditional response |
| resp_x | output | 1 | Command accepted |
| lam_req | output | 1 | Service request |
| unit_clr | output | 1 | One-cycle clear to the digitizer |
| inputs_inhibit | output | 1 | Inhibit to the channel inputs |

## Verification
A LAM flag in the wrong state shows at `resp_q` on the next function 8 or 10 test during strobe 1. It also shows directly at `lam_req` one cycle after the faulty edge. A stale strobe-2 edge register shows up in the cycle after a strobe-2 rise: either a missing or doubled `unit_clr` pulse, or a LAM that was not cleared. The bench sweeps every function and subaddress pair, with the LAM both set and clear, so a wrong decode shows immediately at `resp_x` or `resp_q`.

// File: rtl/dataway_cmd_unit.sv
module dataway_cmd_unit #(
  parameter int DATA_W = 24,
  parameter int NUM_CH = 8,
  parameter int FN_W   = 5,
  parameter int SA_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FN_W-1:0]   cmd_fn,
  input  logic [SA_W-1:0]   cmd_sa,
  input  logic              strobe1,
  input  logic              strobe2,
  input  logic              init_z,
  input  logic              clear_c,
  input  logic              inhibit_i,
  input  logic              lam_en,
  input  logic              eow_ext,
  input  logic              eow_int,
  output logic [$clog2(NUM_CH)-1:0] ch_sel,
  input  logic [DATA_W-1:0] ch_data,
  input  logic              ch_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              resp_q,
  output logic              resp_x,
  output logic              lam_req,
  output logic              unit_clr,
  output logic              inputs_inhibit
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [FN_W-1:0] FN_READ   = FN_W'(0);
  localparam logic [FN_W-1:0] FN_RDCLR  = FN_W'(2);
  localparam logic [FN_W-1:0] FN_TEST   = FN_W'(8);
  localparam logic [FN_W-1:0] FN_CLEAR  = FN_W'(9);
  localparam logic [FN_W-1:0] FN_TSTCLR = FN_W'(10);
  localparam logic [SA_W-1:0] SA_LAST   = SA_W'(NUM_CH - 1);

  logic s2_d, eow_d, lam, clr_q;
  logic sa_zero, is_read, is_test, is_clear, is_tstclr, is_rdclr_last;
  logic strobe, s2_rise, eow_now, eow_rise, unit_clr_cmd, lam_clr_cmd;

  assign sa_zero       = (cmd_sa == '0);
  assign is_read       = ((cmd_fn == FN_READ) || (cmd_fn == FN_RDCLR)) && (int'(cmd_sa) < NUM_CH);
  assign is_test       = (cmd_fn == FN_TEST) && sa_zero;
  assign is_clear      = (cmd_fn == FN_CLEAR) && sa_zero;
  assign is_tstclr     = (cmd_fn == FN_TSTCLR) && sa_zero;
  assign is_rdclr_last = (cmd_fn == FN_RDCLR) && (cmd_sa == SA_LAST);

  assign strobe   = strobe1 | strobe2;
  assign s2_rise  = strobe2 & ~s2_d;
  assign eow_now  = eow_ext | eow_int;
  assign eow_rise = eow_now & ~eow_d;

  assign unit_clr_cmd = s2_rise & (init_z | clear_c | is_clear | is_rdclr_last);
  assign lam_clr_cmd  = s2_rise & (init_z | clear_c | is_clear | is_tstclr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_d  <= 1'b0;
      eow_d <= 1'b0;
      lam   <= 1'b0;
      clr_q <= 1'b0;
    end else begin
      s2_d  <= strobe2;
      eow_d <= eow_now;
      clr_q <= unit_clr_cmd;
      if (lam_clr_cmd)
        lam <= 1'b0;
      else if (lam_en && eow_rise)
        lam <= 1'b1;
    end
  end

  assign ch_sel         = cmd_sa[CH_W-1:0];
  assign rd_data        = (strobe && is_read) ? ch_data : '0;
  assign resp_q         = strobe & ((is_read & ch_valid) | ((is_test | is_tstclr) & lam));
  assign resp_x         = is_read | is_test | is_clear | is_tstclr;
  assign lam_req        = lam;
  assign unit_clr       = clr_q;
  assign inputs_inhibit = inhibit_i;

  // R6 R12
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_clr |=> !unit_clr);

  // R5
  tstclr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_rise && is_tstclr) |=> !lam_req);

  // R7
  rdclr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_rise && is_rdclr_last && !init_z && !clear_c && lam_req) |=> (lam_req && unit_clr));

  // R9
  lam_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lam_en && !lam_req) |=> !lam_req);

  // R9
  lam_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lam_req && !strobe2) |=> lam_req);

  // R10
  bad_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_x |-> (!resp_q && rd_data == '0));
endmodule

// File: tb/dataway_cmd_unit_tb_top.sv
`timescale 1ns/1ps
module dataway_cmd_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] cmd_fn = '0;
  logic [3:0] cmd_sa = '0;
  logic strobe1 = 0, strobe2 = 0, init_z = 0, clear_c = 0, inhibit_i = 0;
  logic lam_en = 0, eow_ext = 0, eow_int = 0;
  logic [2:0] ch_sel;
  logic [23:0] ch_data, rd_data;
  logic ch_valid, resp_q, resp_x, lam_req, unit_clr, inputs_inhibit;
  localparam logic [7:0] VMASK = 8'b1011_0110;
  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign ch_data  = 24'h800000 | (24'(ch_sel) * 24'h012345);
  assign ch_valid = VMASK[ch_sel];

  dataway_cmd_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_fn(cmd_fn), .cmd_sa(cmd_sa),
    .strobe1(strobe1), .strobe2(strobe2), .init_z(init_z), .clear_c(clear_c),
    .inhibit_i(inhibit_i), .lam_en(lam_en), .eow_ext(eow_ext), .eow_int(eow_int),
    .ch_sel(ch_sel), .ch_data(ch_data), .ch_valid(ch_valid), .rd_data(rd_data),
    .resp_q(resp_q), .resp_x(resp_x), .lam_req(lam_req), .unit_clr(unit_clr),
    .inputs_inhibit(inputs_inhibit));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic reset_lam();
    tick(); init_z = 1; strobe2 = 1;
    tick(); init_z = 0; strobe2 = 0;
    tick();
  endtask

  task automatic set_lam();
    tick(); lam_en = 1; eow_ext = 1;
    tick(); eow_ext = 0;
  endtask

  task automatic run_pair(input int f, input int a, input bit want);
    bit valid, is_rd, uclr;
    logic [23:0] exp_d;
    logic exp_q, exp_lam;
    reset_lam();
    if (want) set_lam();
    is_rd = (f == 0 || f == 2) && a < 8;
    valid = is_rd || ((f == 8 || f == 9 || f == 10) && a == 0);
    exp_d = is_rd ? (24'h800000 | (24'(a % 8) * 24'h012345)) : 24'h0;
    exp_q = is_rd ? VMASK[a % 8] : (((f == 8 || f == 10) && a == 0) ? want : 1'b0);
    uclr = (f == 9 && a == 0) || (f == 2 && a == 7);
    exp_lam = ((f == 9 || f == 10) && a == 0) ? 1'b0 : want;
    tick(); cmd_fn = 5'(f); cmd_sa = 4'(a); strobe1 = 1;
    #1;
    check(valid ? "R2" : "R10", resp_x, valid);
    check(is_rd ? "R3" : (f == 8 ? "R4" : (f == 10 ? "R5" : "R10")), resp_q, exp_q);
    check(is_rd ? "R3" : "R10", rd_data, exp_d);
    tick(); strobe1 = 0; strobe2 = 1;
    tick(); strobe2 = 0;
    check(f == 9 ? "R6" : (f == 2 ? "R7" : "R10"), unit_clr, uclr);
    check(f == 10 ? "R5" : (f == 9 ? "R6" : "R10"), lam_req, exp_lam);
    tick();
    check("R6", unit_clr, 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    check("R1", lam_req, 0);
    check("R1", unit_clr, 0);
    rst_n = 1;
    tick();
    check("R1", lam_req, 0);

    // R11
    inhibit_i = 1; #1 check("R11", inputs_inhibit, 1);
    inhibit_i = 0; #1 check("R11", inputs_inhibit, 0);

    // R3 no strobe -> idle read lines
    cmd_fn = 0; cmd_sa = 4'd4; #1;
    check("R3", rd_data, 0);
    check("R3", resp_q, 0);
    check("R3", ch_sel, 4);

    // R9 disabled option
    tick(); lam_en = 0; eow_ext = 1;
    tick(); eow_ext = 0;
    check("R9", lam_req, 0);
    // R9 internal source
    tick(); lam_en = 1; eow_int = 1;
    tick();
    check("R9", lam_req, 1);
    // R5 clear while event still held; no re-set without new edge
    cmd_fn = 10; cmd_sa = 0; strobe2 = 1;
    tick(); strobe2 = 0;
    check("R5", lam_req, 0);
    check("R5", unit_clr, 0);
    tick(); tick();
    check("R9", lam_req, 0);
    eow_int = 0;
    tick();

    // R8 clear line
    set_lam();
    tick(); cmd_fn = 5'd17; cmd_sa = 4'd9; clear_c = 1; strobe2 = 1;
    tick(); clear_c = 0; strobe2 = 0;
    check("R8", unit_clr, 1);
    check("R8", lam_req, 0);

    // R12 held strobe2
    tick(); cmd_fn = 9; cmd_sa = 0; strobe2 = 1;
    tick();
    check("R12", unit_clr, 1);
    tick();
    check("R12", unit_clr, 0);
    tick();
    check("R12", unit_clr, 0);
    strobe2 = 0;
    tick();

    // R2 R3 R4 R5 R6 R7 R10 full sweep
    for (int f = 0; f < 32; f++)
      for (int a = 0; a < 16; a++)
        for (int w = 0; w < 2; w++)
          run_pair(f, a, w[0]);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule